// File: doc/BRIEF.md
# Bidirectional Multi-Line Row Scanner

This block is the scanning engine of a row driver for a multi-line-addressed LCD. It moves one token along a chain of 40 stages. Each stage enables a group of four adjacent common lines, so the chain covers 160 lines. A frame-start pulse loads the token, and each falling edge of the line clock then advances it by one group. When the token runs off the far end of the chain, the block sends a one-step cascade pulse toward the next driver chip.

The scan direction can be reversed. When it is, the two cascade pins swap their input and output roles. A narrow mode restricts the scan to lines 8 through 147. A half-period mode holds each group for two line clocks. A follower chip takes its start pulse from the cascade input instead of from the frame-start pin.

The block is a synchronous model. It registers the line clock on the system clock and acts on the detected falling edge. The grouped one-hot select vector goes to the pattern and level logic downstream.

Top module: `mls_row_scanner`

## Requirements
- R1: While `rst_n` is low, `grp_sel` reads zero and both cascade outputs read zero. Reset also clears the half-period phase.
- R2: With `dir_rev`=0 and `win_narrow`=0, a start sampled at a line-clock falling edge leaves only `grp_sel` bit 0 set.
- R3: Each later falling edge moves the single set bit one position in the scan direction. `grp_sel` never has more than one bit set.
- R4: With `dir_rev`=1, a start selects bit 39 and later falling edges move the token toward bit 0. In this direction `casc_b_in` is the cascade input and `casc_a_out` is the cascade output. With `dir_rev`=0, `casc_a_in` is the input and `casc_b_out` is the output.
- R5: With `win_narrow`=1, the active groups are 2 through 36 (lines 8 to 147). Forward scans start at group 2 and end at group 36. Reverse scans start at group 36 and end at group 2. Groups 0, 1 and 37 to 39 are never selected.
- R6: `grp_sel` and the cascade outputs change only on a detected falling edge of `line_clk`. A rising edge, or a steady level, leaves them unchanged.
- R7: When the token leaves the last active group, `grp_sel` becomes zero and the active cascade output is high for exactly one step. The cascade pin acting as input always drives zero.
- R8: With `follower`=1, the start comes from the active cascade input and `frame_start` is ignored. With `follower`=0, the start comes from `frame_start`.
- R9: With `half_mode`=1, each group, and also the cascade pulse, stays for two line-clock falling edges before the next step.
- R10: A start sampled while a scan is in progress reloads the first active group at once, whatever the token's position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| line_clk | input | 1 | Line clock; the block steps on its falling edge |
| frame_start | input | 1 | Start pulse for a leading chip |
| casc_a_in | input | 1 | Cascade input when `dir_rev`=0 |
| casc_b_in | input | 1 | Cascade input when `dir_rev`=1 |
| dir_rev | input | 1 | 0: scan upward from group 0; 1: scan downward |
| win_narrow | input | 1 | 1: scan only lines 8 to 147 |
| half_mode | input | 1 | 1: hold each step for two line clocks |
| follower | input | 1 | 1: start from the cascade input |
| grp_sel | output | 40 | One-hot group select; bit g enables lines 4g to 4g+3 |
| casc_a_out | output | 1 | Cascade output when `dir_rev`=1 |
| casc_b_out | output | 1 | Cascade output when `dir_rev`=0 |

## Verification
On every cycle the assertions check these properties:
- The select vector is never more than one-hot.
- No out-of-window group is selected after an update in narrow mode.
- Outputs move only after a line-clock falling edge.
- The cascade pin acting as input never drives.

The following behaviours can only be shown by the directed scenarios:
- The start and end groups for each direction and window.
- The exact step sequence and the length of the cascade pulse.
- Which start source a follower chip obeys.
- The two-clock hold in half-period mode.
- A restart in the middle of a scan.

// File: rtl/mls_row_scanner.sv
module mls_row_scanner #(
  parameter int GROUPS  = 40,
  parameter int LO_GRP  = 2,
  parameter int HI_GRP  = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_clk,
  input  logic              frame_start,
  input  logic              casc_a_in,
  input  logic              casc_b_in,
  input  logic              dir_rev,
  input  logic              win_narrow,
  input  logic              half_mode,
  input  logic              follower,
  output logic [GROUPS-1:0] grp_sel,
  output logic              casc_a_out,
  output logic              casc_b_out
);
  localparam int IW = $clog2(GROUPS);

  logic [GROUPS-1:0] chain, shifted, in_win;
  logic              lclk_q, phase, casc_q;
  logic              fall, start_in, last_bit;
  logic [IW-1:0]     first_idx, last_idx;

  assign fall     = lclk_q & ~line_clk;
  assign start_in = follower ? (dir_rev ? casc_b_in : casc_a_in) : frame_start;

  assign first_idx = dir_rev ? (win_narrow ? IW'(HI_GRP) : IW'(GROUPS-1))
                             : (win_narrow ? IW'(LO_GRP) : IW'(0));
  assign last_idx  = dir_rev ? (win_narrow ? IW'(LO_GRP) : IW'(0))
                             : (win_narrow ? IW'(HI_GRP) : IW'(GROUPS-1));
  assign last_bit  = chain[last_idx];

  for (genvar i = 0; i < GROUPS; i++) begin : g_stage
    localparam bit INW = (i >= LO_GRP) && (i <= HI_GRP);
    logic from_lo, from_hi;
    if (i == 0) begin : g_lo_edge
      assign from_lo = 1'b0;
    end else begin : g_lo_mid
      assign from_lo = chain[i-1];
    end
    if (i == GROUPS-1) begin : g_hi_edge
      assign from_hi = 1'b0;
    end else begin : g_hi_mid
      assign from_hi = chain[i+1];
    end
    assign in_win[i]  = INW | ~win_narrow;
    assign shifted[i] = in_win[i] & (dir_rev ? from_hi : from_lo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lclk_q <= 1'b0;
      chain  <= '0;
      phase  <= 1'b0;
      casc_q <= 1'b0;
    end else begin
      lclk_q <= line_clk;
      if (fall) begin
        if (start_in) begin
          chain  <= GROUPS'(1) << first_idx;
          casc_q <= last_bit;
          phase  <= half_mode;
        end else if (phase && half_mode) begin
          phase  <= 1'b0;
        end else begin
          chain  <= shifted;
          casc_q <= last_bit;
          phase  <= half_mode;
        end
      end
    end
  end

  assign grp_sel    = chain;
  assign casc_b_out = casc_q & ~dir_rev;
  assign casc_a_out = casc_q &  dir_rev;
endmodule

// File: rtl/mls_row_scanner_chk.sv
module mls_row_scanner_chk #(
  parameter int GROUPS = 40,
  parameter int LO_GRP = 2,
  parameter int HI_GRP = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_clk,
  input logic              dir_rev,
  input logic              win_narrow,
  input logic [GROUPS-1:0] grp_sel,
  input logic              casc_a_out,
  input logic              casc_b_out
);
  logic [GROUPS-1:0] outside;
  for (genvar i = 0; i < GROUPS; i++) begin : g_out
    assign outside[i] = (i < LO_GRP) || (i > HI_GRP);
  end

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_sel));

  // R5
  narrow_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_narrow && $past(win_narrow) && !$stable(grp_sel)) |-> ((grp_sel & outside) == '0));

  // R6
  sel_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(grp_sel) |-> ($past(line_clk, 2) && !$past(line_clk)));

  // R6
  casc_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(casc_a_out | casc_b_out) |-> ($past(line_clk, 2) && !$past(line_clk)));

  // R7
  idle_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_rev ? !casc_b_out : !casc_a_out);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (grp_sel == '0 && !casc_a_out && !casc_b_out));
endmodule

bind mls_row_scanner mls_row_scanner_chk #(
  .GROUPS(GROUPS), .LO_GRP(LO_GRP), .HI_GRP(HI_GRP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .dir_rev(dir_rev),
  .win_narrow(win_narrow), .grp_sel(grp_sel),
  .casc_a_out(casc_a_out), .casc_b_out(casc_b_out)
);

// File: tb/mls_row_scanner_tb.sv
`timescale 1ns/1ps
module mls_row_scanner_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic line_clk = 1'b0, frame_start = 1'b0, casc_a_in = 1'b0, casc_b_in = 1'b0;
  logic dir_rev = 1'b0, win_narrow = 1'b0, half_mode = 1'b0, follower = 1'b0;
  logic [39:0] grp_sel;
  logic casc_a_out, casc_b_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mls_row_scanner dut_i (
    .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .frame_start(frame_start),
    .casc_a_in(casc_a_in), .casc_b_in(casc_b_in), .dir_rev(dir_rev),
    .win_narrow(win_narrow), .half_mode(half_mode), .follower(follower),
    .grp_sel(grp_sel), .casc_a_out(casc_a_out), .casc_b_out(casc_b_out)
  );

  task automatic pulse(input logic st);
    @(negedge clk); line_clk = 1'b1; frame_start = st;
    repeat (2) @(negedge clk);
    line_clk = 1'b0;
    repeat (3) @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic chk_sel(input int idx, input string req);
    logic [39:0] exp;
    exp = (idx < 0) ? 40'd0 : (40'd1 << idx);
    checks++;
    if (grp_sel !== exp) begin
      errors++;
      $display("FAIL %s: grp_sel=%h expected %h", req, grp_sel, exp);
    end
  endtask

  task automatic chk_casc(input logic a, input logic b, input string req);
    checks++;
    if (casc_a_out !== a || casc_b_out !== b) begin
      errors++;
      $display("FAIL %s: casc a/b=%b%b expected %b%b", req, casc_a_out, casc_b_out, a, b);
    end
  endtask

  task automatic t_reset;
    chk_sel(-1, "R1"); chk_casc(0, 0, "R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_sel(-1, "R1");
  endtask

  task automatic t_forward;
    dir_rev = 0; win_narrow = 0; half_mode = 0; follower = 0;
    pulse(1); chk_sel(0, "R2"); chk_casc(0, 0, "R2");
    for (int k = 1; k < 40; k++) begin
      pulse(0); chk_sel(k, "R3");
    end
    chk_casc(0, 0, "R7");
    pulse(0); chk_sel(-1, "R7"); chk_casc(0, 1, "R7");
    pulse(0); chk_casc(0, 0, "R7");
  endtask

  task automatic t_stable;
    pulse(1); chk_sel(0, "R6");
    @(negedge clk); line_clk = 1'b1; frame_start = 1'b1;
    repeat (6) @(negedge clk);
    chk_sel(0, "R6");
    frame_start = 1'b0; line_clk = 1'b0;
    repeat (3) @(negedge clk);
    chk_sel(1, "R6");
  endtask

  task automatic t_restart;
    pulse(1);
    for (int k = 0; k < 5; k++) pulse(0);
    chk_sel(5, "R10");
    pulse(1); chk_sel(0, "R10");
  endtask

  task automatic t_reverse;
    dir_rev = 1; win_narrow = 0;
    pulse(1); chk_sel(39, "R4");
    for (int k = 38; k >= 0; k--) begin
      pulse(0); chk_sel(k, "R4");
    end
    pulse(0); chk_sel(-1, "R7"); chk_casc(1, 0, "R4");
    pulse(0); chk_casc(0, 0, "R7");
  endtask

  task automatic t_narrow;
    dir_rev = 0; win_narrow = 1;
    pulse(1); chk_sel(2, "R5");
    for (int k = 3; k <= 36; k++) begin
      pulse(0); chk_sel(k, "R5");
    end
    pulse(0); chk_sel(-1, "R5"); chk_casc(0, 1, "R5");
    dir_rev = 1;
    pulse(1); chk_sel(36, "R5");
    pulse(0); chk_sel(35, "R5");
    for (int k = 0; k < 33; k++) pulse(0);
    chk_sel(2, "R5");
    pulse(0); chk_sel(-1, "R5"); chk_casc(1, 0, "R5");
    pulse(0);
    win_narrow = 0;
  endtask

  task automatic t_follower;
    follower = 1; dir_rev = 0;
    pulse(1); chk_sel(-1, "R8");
    casc_b_in = 1'b1; pulse(0); casc_b_in = 1'b0; chk_sel(-1, "R8");
    casc_a_in = 1'b1; pulse(0); casc_a_in = 1'b0; chk_sel(0, "R8");
    dir_rev = 1;
    casc_b_in = 1'b1; pulse(0); casc_b_in = 1'b0; chk_sel(39, "R4");
    pulse(0); chk_sel(38, "R8");
    follower = 0; dir_rev = 0;
  endtask

  task automatic t_half;
    half_mode = 1;
    pulse(1); chk_sel(0, "R9");
    pulse(0); chk_sel(0, "R9");
    pulse(0); chk_sel(1, "R9");
    pulse(0); chk_sel(1, "R9");
    pulse(0); chk_sel(2, "R9");
    for (int k = 3; k < 40; k++) begin
      pulse(0); pulse(0); chk_sel(k, "R9");
    end
    pulse(0); chk_sel(39, "R9");
    pulse(0); chk_sel(-1, "R9"); chk_casc(0, 1, "R9");
    pulse(0); chk_casc(0, 1, "R9");
    pulse(0); chk_casc(0, 0, "R9");
    half_mode = 0;
  endtask

  task automatic t_reset_mid;
    pulse(1); pulse(0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk_sel(-1, "R1"); chk_casc(0, 0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_forward();
    t_stable();
    t_restart();
    t_reverse();
    t_narrow();
    t_follower();
    t_half();
    t_reset_mid();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule